// File: doc/BRIEF.md
# Programmable-Skew Triple-Sample Filtering Register

This block is one pipeline register position that is hardened against single-event transients on its data input. A stage-enable pulse starts a capture sequence. The same input word is captured three times, at instants spaced by a programmable skew. A bitwise majority of the three captures then becomes the registered output of the stage. If a transient is shorter than the skew, it can corrupt at most one of the three captures, and the vote removes it.

The skew is counted in ticks of the single fast clock. A larger skew tolerates longer transients, at the cost of a longer sequence. When registers of this kind are chained, a glitch from the voter of one stage is just another transient at the input of the next stage, so the next stage's triple capture removes it too. The skew is sampled once, when a sequence starts. A stage-enable that arrives while a sequence is running is rejected and flagged.

Top module: `tsf_filter_reg`

## Requirements
- R1: While `rst_n` is low at a clock edge, `dout` becomes all zeros and `dout_vld` and `overrun` become 0.
- R2: When `stage_en` is accepted at an edge t, `din` is captured at edge t, again at edge t+D and again at edge t+2D. Values of `din` at all other edges of the sequence do not affect the result.
- R3: The result is the bitwise majority of the three captures: each output bit is 1 exactly when at least two of the three captured bits are 1.
- R4: When exactly one of the three captures differs from the other two, the output equals the two captures that agree. This holds whether the difference comes from upstream logic or from an upstream voter.
- R5: `skew_cfg` is an unsigned 4-bit count, so D = `skew_cfg` for values 1 to 15 and D = 1 when `skew_cfg` is 0. The three capture instants never coincide.
- R6: `dout` takes the voted value at edge t+2D+1. `dout_vld` is 1 for exactly the one cycle after that edge. `dout` holds its value at every other edge.
- R7: A `stage_en` sampled at any edge from t through t+2D (inclusive) is ignored, and it sets `overrun` to 1 for the following cycle. A `stage_en` at edge t+2D+1 or later starts a new sequence.
- R8: The skew is latched at edge t. Changing `skew_cfg` during a sequence does not move that sequence's second or third capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock; every capture instant is one of its rising edges |
| rst_n | input | 1 | Synchronous active-low reset |
| stage_en | input | 1 | Start-of-sequence strobe for this register position |
| skew_cfg | input | 4 | Capture spacing in clock ticks (0 behaves as 1) |
| din | input | DATA_W | Data word to be captured |
| dout | output | DATA_W | Registered majority of the three captures |
| dout_vld | output | 1 | One-cycle pulse marking a new `dout` value |
| overrun | output | 1 | One-cycle pulse marking a rejected `stage_en` |

## Verification
The bench drives junk on `din` at every edge except the three intended capture instants. If the tick counter or the latched skew is wrong, the block captures junk instead of a real sample. That shows as a wrong `dout` no later than edge t+2D+1, which is at most 31 cycles after the start.

If the busy state is wrong, the symptoms appear at the ports. A busy flag stuck high shows as stray `overrun` pulses, or as a missing `dout_vld` in the cycle after edge t+2D+1. A busy flag that clears early lets a mid-sequence `stage_en` restart the capture, which corrupts the next result.

A voter fault on any single bit appears in the first sequence whose captures disagree on that bit.

// File: rtl/tsf_pkg.sv
// Package: shared types for the triple-sample filtering register.
// Assumes: strobes are single-cycle enables in the one fast clock domain.
package tsf_pkg;

    // Number of time-skewed captures per register position.
    localparam int unsigned TSF_NUM_CAPT = 3;

    // One enable per capture instant; bit 0 is the earliest capture.
    typedef struct packed {
        logic third;
        logic second;
        logic first;
    } tsf_strobe_t;

endpackage

// File: rtl/tsf_strobe_gen.sv
// Module: tsf_strobe_gen
// Turns an accepted stage-enable into three capture strobes that are spaced
// by a skew latched at the start, and raises an overrun pulse for requests
// made while busy.
// Assumes: skew_cfg is stable only around the start edge; it is read once.
module tsf_strobe_gen
    import tsf_pkg::*;
#(
    parameter int unsigned SKEW_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic [SKEW_W-1:0] skew_cfg,
    output tsf_strobe_t       strb,
    output logic              busy,
    output logic              last_q,
    output logic              overrun,
    output logic [SKEW_W-1:0] dt_lat
);

    // The counter must reach 2 * max skew.
    localparam int unsigned CNT_W = SKEW_W + 1;

    logic [CNT_W-1:0]  cnt;
    logic [SKEW_W-1:0] dt_eff;

    // Map a zero skew to one tick so that the strobes stay distinct.
    always_comb dt_eff = (skew_cfg == '0) ? SKEW_W'(1) : skew_cfg;

    // Decode the three capture instants from the idle state and the tick count.
    always_comb begin
        strb.first  = start_req & ~busy;
        strb.second = busy & (cnt == {1'b0, dt_lat});
        strb.third  = busy & (cnt == {dt_lat, 1'b0});
    end

    // Run the sequence state: busy flag, tick counter and latched skew.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            cnt    <= '0;
            dt_lat <= SKEW_W'(1);
        end else if (strb.first) begin
            busy   <= 1'b1;
            cnt    <= CNT_W'(1);
            dt_lat <= dt_eff;
        end else if (strb.third) begin
            busy   <= 1'b0;
            cnt    <= '0;
        end else if (busy) begin
            cnt    <= cnt + CNT_W'(1);
        end
    end

    // Register the end-of-sequence marker and the rejected-request pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q  <= 1'b0;
            overrun <= 1'b0;
        end else begin
            last_q  <= strb.third;
            overrun <= start_req & busy;
        end
    end

endmodule

// File: rtl/tsf_capture.sv
// Module: tsf_capture
// A bank of capture registers that all read the same data input. Each one
// loads on its own strobe.
// Assumes: at most one strobe is active per cycle (not required for function).
module tsf_capture
    import tsf_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [TSF_NUM_CAPT-1:0]              load,
    input  logic [DATA_W-1:0]                    din,
    output logic [TSF_NUM_CAPT-1:0][DATA_W-1:0]  cap
);

    for (genvar g = 0; g < TSF_NUM_CAPT; g++) begin : g_cap
        // Hold the sample taken at capture instant g.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cap[g] <= '0;
            else if (load[g])
                cap[g] <= din;
        end
    end

endmodule

// File: rtl/tsf_voter.sv
// Module: tsf_voter
// Bitwise two-of-three majority over the captures, registered into the
// stage output together with a one-cycle valid pulse.
// Assumes: the captures are stable in the cycle that load is high.
module tsf_voter
    import tsf_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 load,
    input  logic [TSF_NUM_CAPT-1:0][DATA_W-1:0]  cap,
    output logic [DATA_W-1:0]                    dout,
    output logic                                 dout_vld
);

    logic [DATA_W-1:0] maj;

    // Two-of-three majority for each bit.
    always_comb maj = (cap[0] & cap[1]) | (cap[0] & cap[2]) | (cap[1] & cap[2]);

    // Load the voted word and flag it for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout     <= '0;
            dout_vld <= 1'b0;
        end else begin
            dout_vld <= load;
            if (load)
                dout <= maj;
        end
    end

endmodule

// File: rtl/tsf_filter_reg.sv
// Module: tsf_filter_reg (top)
// A pipeline register position that filters transients. It captures din
// three times, spaced by a programmable number of ticks, then registers the
// bitwise majority.
// Assumes: a single clock; skew_cfg is read only on the edge that starts a sequence.
module tsf_filter_reg
    import tsf_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned SKEW_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stage_en,
    input  logic [SKEW_W-1:0] skew_cfg,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_vld,
    output logic              overrun
);

    tsf_strobe_t                          strb;
    logic [TSF_NUM_CAPT-1:0]              strb_vec;
    logic                                 busy;
    logic                                 last_q;
    logic [SKEW_W-1:0]                    dt_lat;
    logic [TSF_NUM_CAPT-1:0][DATA_W-1:0]  cap;

    // Flatten the strobe struct into a vector; bit 0 is the earliest capture.
    always_comb strb_vec = strb;

    tsf_strobe_gen #(.SKEW_W(SKEW_W)) u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (stage_en),
        .skew_cfg  (skew_cfg),
        .strb      (strb),
        .busy      (busy),
        .last_q    (last_q),
        .overrun   (overrun),
        .dt_lat    (dt_lat)
    );

    tsf_capture #(.DATA_W(DATA_W)) u_capture (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (strb_vec),
        .din   (din),
        .cap   (cap)
    );

    tsf_voter #(.DATA_W(DATA_W)) u_voter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (last_q),
        .cap      (cap),
        .dout     (dout),
        .dout_vld (dout_vld)
    );

endmodule

// File: rtl/tsf_filter_reg_chk.sv
// Module: tsf_filter_reg_chk
// Temporal checks on tsf_filter_reg, attached through bind.
// Assumes: it is connected to the top's ports and to the strobe-generator state.
module tsf_filter_reg_chk #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned SKEW_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stage_en,
    input logic [DATA_W-1:0] dout,
    input logic              dout_vld,
    input logic              overrun,
    input logic [2:0]        strb_vec,
    input logic              busy,
    input logic [SKEW_W-1:0] dt_lat
);

    AST_VLD_SINGLE:  assert property (@(posedge clk) disable iff (!rst_n)
        dout_vld |=> !dout_vld);                                     // R6
    AST_DOUT_HELD:   assert property (@(posedge clk) disable iff (!rst_n)
        !dout_vld |-> $stable(dout));                                // R6
    AST_VOTE_AFTER:  assert property (@(posedge clk) disable iff (!rst_n)
        strb_vec[2] |=> ##1 dout_vld);                               // R6
    AST_STROBE_SEP:  assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strb_vec));                                         // R5
    AST_OVR_CAUSE:   assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> ($past(stage_en) && $past(busy)));               // R7
    AST_SKEW_HELD:   assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(dt_lat));                  // R8

endmodule

bind tsf_filter_reg tsf_filter_reg_chk #(.DATA_W(DATA_W), .SKEW_W(SKEW_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .stage_en (stage_en),
    .dout     (dout),
    .dout_vld (dout_vld),
    .overrun  (overrun),
    .strb_vec (strb_vec),
    .busy     (busy),
    .dt_lat   (dt_lat)
);

// File: tb/tsf_filter_reg_bench.sv
// Bench for tsf_filter_reg. It sweeps every skew setting with clean,
// single-fault, mixed, skew-change and overrun sequences.
module tsf_filter_reg_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       stage_en;
    logic [3:0] skew_cfg;
    logic [7:0] din;
    logic [7:0] dout;
    logic       dout_vld;
    logic       overrun;

    int n_run  = 0;
    int n_fail = 0;
    int ov_cnt = 0;

    always #10 clk = ~clk;   // 50 MHz

    tsf_filter_reg u_tsf_filter_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .stage_en (stage_en),
        .skew_cfg (skew_cfg),
        .din      (din),
        .dout     (dout),
        .dout_vld (dout_vld),
        .overrun  (overrun)
    );

    // Count overrun pulses seen away from the clock edge.
    always @(negedge clk) if (rst_n && overrun) ov_cnt++;

    function automatic logic [7:0] maj3(input logic [7:0] a, b, c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One capture sequence. It starts at the next rising edge; the caller is at a negedge.
    task automatic run_seq(input logic [3:0] cfg, input logic [7:0] c0, c1, c2,
                           input int ov_at, input logic [3:0] cfg_mid, input string req);
        int d;
        int ov0;
        bit early_vld;
        logic [7:0] prev;
        d = (cfg == 4'd0) ? 1 : int'(cfg);
        ov0 = ov_cnt;
        early_vld = 1'b0;
        stage_en = 1'b1; din = c0; skew_cfg = cfg;
        for (int i = 1; i <= 2 * d; i++) begin
            @(negedge clk);
            if (dout_vld) early_vld = 1'b1;
            stage_en = (i == ov_at);
            skew_cfg = cfg_mid;
            din = (i == d) ? c1 : (i == 2 * d) ? c2 : 8'($urandom);
        end
        @(negedge clk);                         // after edge t+2D
        stage_en = 1'b0; din = 8'($urandom);
        check(!early_vld && !dout_vld, {req, "/R6 no early valid"}, dout_vld, 0);
        @(negedge clk);                         // after edge t+2D+1
        check(dout_vld == 1'b1, {req, "/R6 valid pulse"}, dout_vld, 1);
        check(dout == maj3(c0, c1, c2), {req, "/R2 R3 voted value"}, dout, maj3(c0, c1, c2));
        prev = dout;
        @(negedge clk);
        check(!dout_vld && dout == prev, {req, "/R6 one-cycle valid, held"}, dout_vld, 0);
        check(ov_cnt - ov0 == ((ov_at > 0) ? 1 : 0), {req, "/R7 overrun count"},
              ov_cnt - ov0, (ov_at > 0) ? 1 : 0);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v, x;
        int d;
        rst_n = 1'b0; stage_en = 1'b0; skew_cfg = 4'd0; din = 8'h00;
        repeat (3) @(negedge clk);
        check(dout == 8'h00, "R1 dout reset", dout, 0);
        check(!dout_vld && !overrun, "R1 flags reset", {dout_vld, overrun}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int cfg = 0; cfg < 16; cfg++) begin
            d = (cfg == 0) ? 1 : cfg;
            v = 8'($urandom);
            x = ~v;
            run_seq(4'(cfg), v, v, v, -1, 4'(cfg), "R2 R5 clean");
            run_seq(4'(cfg), x, v, v, -1, 4'(cfg), "R4 first capture hit");
            run_seq(4'(cfg), v, x, v, -1, 4'(cfg), "R4 second capture hit");
            run_seq(4'(cfg), v, v, x, -1, 4'(cfg), "R4 third capture hit");
            run_seq(4'(cfg), 8'($urandom), 8'($urandom), 8'($urandom), -1, 4'(cfg), "R3 mixed");
            run_seq(4'(cfg), v, x, v, -1, 4'((cfg + 7) % 16), "R8 skew change");
            run_seq(4'(cfg), v, v, x, d, 4'(cfg), "R7 overrun mid");
            run_seq(4'(cfg), x, v, v, 2 * d, 4'(cfg), "R7 overrun last");
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule